// File: doc/BRIEF.md
# Channel command stream decoder

This block sits between a channel DMA front end and a set of engine register files. It receives a stream of 32-bit command words and turns them into register-write transactions. Each transaction carries a method offset, a data word and the engine class that was selected last. Some command words are headers and some are payload. A header selects an engine class, starts a counted burst (with the offset advancing or fixed), starts a bit-mask-addressed burst, or issues one immediate write that needs no payload.

Words arrive on a valid/ready stream, and writes leave on a valid/ready port through a single output register. Under back-pressure the input stalls, so no word is lost or duplicated. An unknown submission mode in a header is dropped without disturbing the parser and raises a sticky error flag. Only reset clears that flag.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After synchronous reset, `outValid` and `errFlag` are low, the class is 0, no payload is pending and the next word is decoded as a header.
- R2: A header carries the mode in bits 31:28, the method offset in bits 27:16 and a value field in bits 15:0. The mode codes are 0 set-class, 1 incrementing, 2 non-incrementing, 3 mask and 4 immediate.
- R3: A set-class header loads the class from bits 15:6, the base offset from bits 27:16 and a 6-bit payload mask from bits 5:0.
- R4: While the mask is non-zero, every accepted word is payload and never a header. It is written to base offset plus the index of the lowest set mask bit (modulo 4096), and that bit is then cleared. A pending mask takes priority over a pending count.
- R5: An incrementing header loads a 16-bit count and an offset. Each of the next count words is written to the current offset, and the offset then advances by one modulo 4096.
- R6: A non-incrementing header behaves as R5, except that every payload word goes to the same offset.
- R7: An immediate header produces one write at once to offset bits 27:16. Its data is header bits 11:0 zero-extended to 32 bits, and no payload follows.
- R8: Every write carries the class loaded by the most recent set-class header.
- R9: A set-class header with mask 0, or a count header with count 0, takes no payload. The next word is a header.
- R10: A header with mode code 5 to 15 produces no write and leaves class, offset, count and mask unchanged. It sets `errFlag`, which stays high until reset.
- R11: While `outValid` is high and `outReady` is low, the output fields hold steady and `inReady` is low. Every accepted payload or immediate word yields exactly one write, in order.
- R12: A mask header loads a 16-bit mask from bits 15:0, and its payload words go out in ascending bit order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Command word valid |
| inReady | output | 1 | Decoder can take a word |
| inWord | input | 32 | Command word |
| outValid | output | 1 | Register write valid |
| outReady | input | 1 | Downstream takes the write |
| outClass | output | 10 | Engine class of the write |
| outOffset | output | 12 | Method offset of the write |
| outData | output | 32 | Write data |
| errFlag | output | 1 | Sticky unknown-mode error |

## Verification
The hardest cases to reach are the payload words that look like headers. A payload word can carry an immediate or unknown mode code in its top nibble while a mask or count is still pending. The same is true for offsets that wrap past 4095 in the middle of a burst. The stimulus sweeps all 64 set-class masks and several wide masks and counts with base offsets near the top of the range. It fills payload words with patterns whose top nibble varies. A later pass repeats the mix while the write port is randomly throttled, to exercise the stall path.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int HDR_W      = 32;
  localparam int MODE_W     = 4;
  localparam int OFFS_W     = 12;
  localparam int VAL_W      = 16;
  localparam int CLASS_W    = 10;
  localparam int SMASK_W    = 6;
  localparam int IMM_W      = 12;
  localparam int MODE_LO    = HDR_W - MODE_W;
  localparam int OFFS_LO    = VAL_W;
  localparam int CLASS_LO   = SMASK_W;
  localparam int LBS_W      = $clog2(VAL_W);

  typedef enum logic [MODE_W-1:0] {
    MODE_SETCLASS = 4'd0,
    MODE_INCR     = 4'd1,
    MODE_NONINCR  = 4'd2,
    MODE_MASK     = 4'd3,
    MODE_IMM      = 4'd4
  } mode_e;

  typedef struct packed {
    logic emitMask;
    logic emitCount;
    logic emitImm;
    logic loadClass;
    logic loadWideMask;
    logic loadCount;
    logic incrFlag;
    logic errSet;
  } ctl_s;
endpackage

// File: rtl/csd_ctrl.sv
module csd_ctrl
  import csd_pkg::*;
(
  input  logic              inValid,
  input  logic [MODE_W-1:0] modeBits,
  input  logic              maskPending,
  input  logic              countPending,
  input  logic              outValid,
  input  logic              outReady,
  output logic              inReady,
  output ctl_s              ctl
);
  logic slotFree;
  logic fire;

  assign slotFree = !outValid || outReady;
  assign inReady  = slotFree;
  assign fire     = inValid && slotFree;

  always_comb begin
    ctl = '0;
    if (fire) begin
      if (maskPending) begin
        ctl.emitMask = 1'b1;
      end else if (countPending) begin
        ctl.emitCount = 1'b1;
      end else begin
        unique case (modeBits)
          MODE_SETCLASS: ctl.loadClass = 1'b1;
          MODE_INCR: begin
            ctl.loadCount = 1'b1;
            ctl.incrFlag  = 1'b1;
          end
          MODE_NONINCR:  ctl.loadCount    = 1'b1;
          MODE_MASK:     ctl.loadWideMask = 1'b1;
          MODE_IMM:      ctl.emitImm      = 1'b1;
          default:       ctl.errSet       = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/csd_datapath.sv
module csd_datapath
  import csd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctl_s               ctl,
  input  logic [HDR_W-1:0]   inWord,
  input  logic               outReady,
  output logic               maskPending,
  output logic               countPending,
  output logic               outValid,
  output logic [CLASS_W-1:0] outClass,
  output logic [OFFS_W-1:0]  outOffset,
  output logic [HDR_W-1:0]   outData,
  output logic               errFlag
);
  logic [VAL_W-1:0]   maskReg;
  logic [VAL_W-1:0]   countReg;
  logic [OFFS_W-1:0]  offReg;
  logic               incrReg;
  logic [CLASS_W-1:0] classReg;
  logic [LBS_W-1:0]   lowIdx;
  logic [OFFS_W-1:0]  hdrOffset;
  logic [VAL_W-1:0]   hdrValue;

  assign hdrOffset    = inWord[OFFS_LO +: OFFS_W];
  assign hdrValue     = inWord[VAL_W-1:0];
  assign maskPending  = |maskReg;
  assign countPending = |countReg;

  always_comb begin
    lowIdx = '0;
    for (int i = VAL_W - 1; i >= 0; i--) begin
      if (maskReg[i]) lowIdx = LBS_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskReg   <= '0;
      countReg  <= '0;
      offReg    <= '0;
      incrReg   <= 1'b0;
      classReg  <= '0;
      outValid  <= 1'b0;
      outClass  <= '0;
      outOffset <= '0;
      outData   <= '0;
      errFlag   <= 1'b0;
    end else begin
      if (outValid && outReady) outValid <= 1'b0;
      if (ctl.emitMask) begin
        outValid  <= 1'b1;
        outClass  <= classReg;
        outOffset <= offReg + OFFS_W'(lowIdx);
        outData   <= inWord;
        maskReg   <= maskReg & (maskReg - 1'b1);
      end
      if (ctl.emitCount) begin
        outValid  <= 1'b1;
        outClass  <= classReg;
        outOffset <= offReg;
        outData   <= inWord;
        countReg  <= countReg - 1'b1;
        if (incrReg) offReg <= offReg + 1'b1;
      end
      if (ctl.emitImm) begin
        outValid  <= 1'b1;
        outClass  <= classReg;
        outOffset <= hdrOffset;
        outData   <= HDR_W'(inWord[IMM_W-1:0]);
        offReg    <= hdrOffset;
      end
      if (ctl.loadClass) begin
        classReg <= inWord[CLASS_LO +: CLASS_W];
        maskReg  <= VAL_W'(inWord[SMASK_W-1:0]);
        offReg   <= hdrOffset;
      end
      if (ctl.loadWideMask) begin
        maskReg <= hdrValue;
        offReg  <= hdrOffset;
      end
      if (ctl.loadCount) begin
        countReg <= hdrValue;
        offReg   <= hdrOffset;
        incrReg  <= ctl.incrFlag;
      end
      if (ctl.errSet) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import csd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [HDR_W-1:0]   inWord,
  output logic               outValid,
  input  logic               outReady,
  output logic [CLASS_W-1:0] outClass,
  output logic [OFFS_W-1:0]  outOffset,
  output logic [HDR_W-1:0]   outData,
  output logic               errFlag
);
  ctl_s ctl;
  logic maskPending;
  logic countPending;
  logic payloadPending;

  assign payloadPending = maskPending || countPending;

  csd_ctrl u_ctrl (
    .inValid      (inValid),
    .modeBits     (inWord[MODE_LO +: MODE_W]),
    .maskPending  (maskPending),
    .countPending (countPending),
    .outValid     (outValid),
    .outReady     (outReady),
    .inReady      (inReady),
    .ctl          (ctl)
  );

  csd_datapath u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .inWord       (inWord),
    .outReady     (outReady),
    .maskPending  (maskPending),
    .countPending (countPending),
    .outValid     (outValid),
    .outClass     (outClass),
    .outOffset    (outOffset),
    .outData      (outData),
    .errFlag      (errFlag)
  );
endmodule

// File: rtl/csd_checker.sv
module csd_checker
  import csd_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic               inReady,
  input logic [HDR_W-1:0]   inWord,
  input logic               outValid,
  input logic               outReady,
  input logic [CLASS_W-1:0] outClass,
  input logic [OFFS_W-1:0]  outOffset,
  input logic [HDR_W-1:0]   outData,
  input logic               errFlag,
  input logic               payloadPending
);
  logic take;
  assign take = inValid && inReady;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!outValid && !errFlag));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outClass) &&
                                 $stable(outOffset) && $stable(outData)));

  assert_stall_R11: assert property (@(posedge clk) disable iff (rst)
    !inReady |-> (outValid && !outReady));

  assert_imm_R7: assert property (@(posedge clk) disable iff (rst)
    (take && !payloadPending && inWord[HDR_W-1 -: MODE_W] == 4'd4) |=>
      (outValid && outOffset == $past(inWord[OFFS_LO +: OFFS_W]) &&
       outData == HDR_W'($past(inWord[IMM_W-1:0]))));

  assert_payload_R4: assert property (@(posedge clk) disable iff (rst)
    (take && payloadPending) |=> (outValid && outData == $past(inWord)));

  assert_unknown_R10: assert property (@(posedge clk) disable iff (rst)
    (take && !payloadPending && inWord[HDR_W-1 -: MODE_W] > 4'd4) |=> errFlag);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);
endmodule

bind cmd_stream_decoder csd_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .inValid        (inValid),
  .inReady        (inReady),
  .inWord         (inWord),
  .outValid       (outValid),
  .outReady       (outReady),
  .outClass       (outClass),
  .outOffset      (outOffset),
  .outData        (outData),
  .errFlag        (errFlag),
  .payloadPending (payloadPending)
);

// File: tb/cmd_stream_decoder_test.sv
module cmd_stream_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inWord = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [9:0]  outClass;
  logic [11:0] outOffset;
  logic [31:0] outData;
  logic        errFlag;

  int vectors = 0;
  int fails = 0;
  bit bpMode = 1'b0;
  bit done = 1'b0;

  logic [9:0]  qClass[$];
  logic [11:0] qOff[$];
  logic [31:0] qData[$];

  logic [15:0] mMask;
  logic [15:0] mCount;
  logic [11:0] mOff;
  logic [9:0]  mClass;
  bit          mInc;
  bit          mErr;
  int          seed = 1;

  always #5 clk = ~clk;

  cmd_stream_decoder uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .outValid(outValid), .outReady(outReady), .outClass(outClass),
    .outOffset(outOffset), .outData(outData), .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic push(input logic [9:0] c, input logic [11:0] o, input logic [31:0] d);
    qClass.push_back(c); qOff.push_back(o); qData.push_back(d);
  endtask

  // Reference of R2..R10 behaviour
  task automatic modelWord(input logic [31:0] w);
    if (mMask != 0) begin
      int b = 0;
      while (!mMask[b]) b++;
      push(mClass, 12'(mOff + 12'(b)), w);
      mMask[b] = 1'b0;
    end else if (mCount != 0) begin
      push(mClass, mOff, w);
      mCount--;
      if (mInc) mOff = mOff + 12'd1;
    end else begin
      case (w[31:28])
        4'd0: begin mClass = w[15:6]; mMask = {10'd0, w[5:0]}; mOff = w[27:16]; end
        4'd1: begin mCount = w[15:0]; mOff = w[27:16]; mInc = 1'b1; end
        4'd2: begin mCount = w[15:0]; mOff = w[27:16]; mInc = 1'b0; end
        4'd3: begin mMask = w[15:0]; mOff = w[27:16]; end
        4'd4: begin push(mClass, w[27:16], {20'd0, w[11:0]}); mOff = w[27:16]; end
        default: mErr = 1'b1;
      endcase
    end
  endtask

  function automatic logic [31:0] hdr(input logic [3:0] m, input logic [11:0] o,
                                      input logic [15:0] v);
    return {m, o, v};
  endfunction

  function automatic logic [31:0] pay();
    seed++;
    return 32'(seed) * 32'h9E3779B1 ^ 32'h4700_0000;
  endfunction

  task automatic sendWord(input logic [31:0] w);
    modelWord(w);
    inWord = w;
    inValid = 1'b1;
    do @(negedge clk); while (!inReady);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) @(posedge clk);
    #1;
  endtask

  // Scoreboard: R11 order / no loss / no duplication
  always @(negedge clk) begin
    if (!rst && outValid && outReady) begin
      if (qData.size() == 0) begin
        check(1'b0, "R11", "unexpected write", {32'd0, outData}, 64'd0);
      end else begin
        logic [9:0] c; logic [11:0] o; logic [31:0] d;
        c = qClass.pop_front(); o = qOff.pop_front(); d = qData.pop_front();
        check(outClass == c, "R8", "class", 64'(outClass), 64'(c));
        check(outOffset == o, "R4/R5/R6/R7", "offset", 64'(outOffset), 64'(o));
        check(outData == d, "R7/R11", "data", 64'(outData), 64'(d));
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      outReady = bpMode ? 1'($urandom % 2) : 1'b1;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic resetModel();
    mMask = '0; mCount = '0; mOff = '0; mClass = '0; mInc = 1'b0; mErr = 1'b0;
  endtask

  task automatic mixedRun();
    sendWord(hdr(4'd0, 12'hFFE, {10'h0F0, 6'b101101}));
    for (int i = 0; i < 4; i++) sendWord(pay());
    sendWord(hdr(4'd1, 12'hFFE, 16'd5));
    for (int i = 0; i < 5; i++) sendWord(pay());
    sendWord(hdr(4'd4, 12'h055, 16'h7777));
    sendWord(hdr(4'd3, 12'h100, 16'h8421));
    for (int i = 0; i < 4; i++) sendWord(pay());
    sendWord(hdr(4'd2, 12'h020, 16'd3));
    for (int i = 0; i < 3; i++) sendWord(pay());
  endtask

  initial begin
    resetModel();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid after reset", 64'(outValid), 64'd0);
    check(errFlag == 1'b0, "R1", "errFlag after reset", 64'(errFlag), 64'd0);
    check(inReady == 1'b1, "R1", "inReady after reset", 64'(inReady), 64'd1);
    @(posedge clk); #1;

    // R1/R7: immediate with class 0
    sendWord(hdr(4'd4, 12'h123, 16'hFABC));
    drain();

    // R3/R4/R8/R9: sweep all 64 set-class masks, near-top base offsets
    for (int m = 0; m < 64; m++) begin
      sendWord(hdr(4'd0, 12'((m * 61 + 32'hFC0) & 32'hFFF),
                   {10'((m * 37 + 5) & 32'h3FF), 6'(m)}));
      for (int k = 0; k < $countones(6'(m)); k++) sendWord(pay());
      sendWord(hdr(4'd4, 12'(m), 16'(m * 3)));
    end
    drain();

    // R5/R6/R9: counted bursts, both modes, offsets that wrap
    for (int mode = 1; mode <= 2; mode++) begin
      for (int n = 0; n <= 5; n++) begin
        sendWord(hdr(4'(mode), 12'(32'hFFD + n), 16'(n)));
        for (int k = 0; k < n; k++) sendWord(pay());
        sendWord(hdr(4'd4, 12'h0AA, 16'(n)));
      end
    end
    drain();

    // R12/R4: wide masks in ascending bit order, wrap at top
    begin
      logic [15:0] masks[6] = '{16'h0001, 16'h8000, 16'hFFFF, 16'hA5A5, 16'h0000, 16'h1230};
      for (int i = 0; i < 6; i++) begin
        sendWord(hdr(4'd3, 12'hFF8, masks[i]));
        for (int k = 0; k < $countones(masks[i]); k++) sendWord(pay());
        sendWord(hdr(4'd4, 12'h3C3, 16'h0FFF));
      end
    end
    // R4: payload words resembling headers (mode 4 / 7) stay payload
    sendWord(hdr(4'd3, 12'h010, 16'h0003));
    sendWord(32'h4123_0456);
    sendWord(32'h7FFF_FFFF);
    sendWord(hdr(4'd2, 12'h011, 16'd2));
    sendWord(32'hF000_0001);
    sendWord(32'h0000_003F);
    drain();
    check(errFlag == 1'b0, "R4", "payload decoded as header", 64'(errFlag), 64'd0);
    check(qData.size() == 0, "R4", "pending writes", 64'(qData.size()), 64'd0);

    // R10: unknown mode dropped, sticky, state undisturbed
    sendWord(hdr(4'd0, 12'h200, {10'h0F0, 6'd0}));
    sendWord(hdr(4'd7, 12'h321, 16'h0003));
    drain();
    check(errFlag == 1'b1, "R10", "errFlag set", 64'(errFlag), 64'd1);
    check(qData.size() == 0, "R10", "write from unknown mode", 64'(qData.size()), 64'd0);
    sendWord(hdr(4'd4, 12'h444, 16'h0555));
    sendWord(hdr(4'd15, 12'h000, 16'hFFFF));
    sendWord(hdr(4'd4, 12'h445, 16'h0556));
    drain();
    check(errFlag == 1'b1, "R10", "errFlag sticky", 64'(errFlag), 64'd1);

    // R11: random back-pressure
    bpMode = 1'b1;
    for (int r = 0; r < 6; r++) mixedRun();
    drain();
    bpMode = 1'b0;
    drain();
    check(qData.size() == 0, "R11", "writes lost", 64'(qData.size()), 64'd0);

    // R1: reset clears the error flag and class
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    resetModel();
    @(negedge clk);
    check(errFlag == 1'b0, "R1", "errFlag after second reset", 64'(errFlag), 64'd0);
    @(posedge clk); #1;
    sendWord(hdr(4'd4, 12'h00F, 16'h1234));
    drain();
    check(qData.size() == 0, "R1", "writes left", 64'(qData.size()), 64'd0);
    check(errFlag == mErr, "R10", "final errFlag", 64'(errFlag), 64'(mErr));

    done = 1'b1;
    summary();
  end
endmodule